// File: doc/BRIEF.md
# Pre-Add Multiply-Accumulate Unit

This block is a pipelined arithmetic datapath. Each enabled cycle it adds two signed pre-adder operands, multiplies their sum by a signed multiplier operand, and adds that product and a 1-bit carry-in into a wide accumulator. Asserting the load control on a cycle makes that cycle's contribution start a new accumulation from an external seed value. Any previously accumulated value is discarded.

Operand widths, accumulator width and pipeline depth are parameters. The latency parameter decides where registers sit: on the operand inputs, after the multiplier, and on the result. A second parameter picks the placement for the two-stage case. The load, seed and carry-in controls travel through their own delay line, so they meet the product of the operands sampled in the same cycle. A single clock enable freezes the whole pipe, including while reset is high.

Top module: `preadd_macc`

## Requirements
- R1: Operands are signed two's complement. The pre-adder sum is formed at PRE_W+1 bits, so two operands at the positive limit do not overflow. The product is (pre_a + pre_b) × mul_op at PRE_W+1+MUL_W bits, then sign-extended to ACC_W.
- R2: With load low, each contribution sets the accumulator to its previous value plus the product plus carry_in.
- R3: With load high, the contribution sets the accumulator to load_val plus the product plus carry_in, and the earlier accumulated value has no effect.
- R4: carry_in adds exactly one to the accumulation on the cycle it accompanies, including when every operand is zero.
- R5: The accumulator wraps modulo 2^ACC_W in both directions.
- R6: For LATENCY L from 1 to 4, operands presented at the n-th enabled clock edge after reset affect result first just after enabled edge n+L-1. With LATENCY 0, result is combinational from the inputs and the accumulator state.
- R7: Register placement: LATENCY 1 has only the post-multiply register. LATENCY 2 has the post-multiply register plus the result register when LAT2_OUTREG=1 (default), or plus one input stage when it is 0. LATENCY 3 has one input stage, the post-multiply register and the result register. LATENCY 4 has two input stages, the post-multiply register and the result register.
- R8: While ce is low, no register changes, whatever rst, load, carry_in or the operands do. Inputs presented in such cycles never reach the accumulator.
- R9: An edge with rst and ce both high clears every pipeline register and the accumulator. For LATENCY of at least 1, result is zero just after that edge.
- R10: load, load_val and carry_in are delayed by the same number of input and post-multiply stages as the operands, so they act on the product of operands presented in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset, gated by ce |
| ce | input | 1 | Clock enable for every register |
| pre_a | input | PRE_W | First pre-adder operand, signed |
| pre_b | input | PRE_W | Second pre-adder operand, signed |
| mul_op | input | MUL_W | Multiplier operand, signed |
| carry_in | input | 1 | Carry added into the accumulation |
| load | input | 1 | Seed the accumulator from load_val this contribution |
| load_val | input | ACC_W | Seed value for a load |
| result | output | ACC_W | Accumulator result |

## Verification
Three copies run side by side on the same stimulus, at LATENCY 1, 3 and 4. An input set taken at the n-th enabled edge is due on each copy's result only after enabled edge n+L-1. The bench keeps a history of the reference accumulator, one entry per enabled input, and counts enabled edges since the last reset. Just after each edge it compares every copy with the history entry L places back, or with zero while fewer than L inputs have entered. Cycles with ce low leave both the edge count and the history unchanged, so held outputs are checked against the same entry.

// File: rtl/preadd_macc_pkg.sv
package preadd_macc_pkg;

    // Where the pipeline registers sit for a given latency choice.
    typedef struct packed {
        logic [1:0] n_in;   // operand input stages
        logic       m_reg;  // register after the multiplier
        logic       p_reg;  // result taken from the accumulator register
    } stage_plan_t;

    function automatic stage_plan_t plan_for(input int lat, input bit lat2_out);
        stage_plan_t p;
        p = '0;
        case (lat)
            1: p.m_reg = 1'b1;
            2: begin
                p.m_reg = 1'b1;
                if (lat2_out) p.p_reg = 1'b1;
                else          p.n_in  = 2'd1;
            end
            3: begin
                p.n_in  = 2'd1;
                p.m_reg = 1'b1;
                p.p_reg = 1'b1;
            end
            4: begin
                p.n_in  = 2'd2;
                p.m_reg = 1'b1;
                p.p_reg = 1'b1;
            end
            default: p = '0;
        endcase
        return p;
    endfunction

    // Stages that the controls cross before reaching the accumulator.
    function automatic int ctl_depth(input stage_plan_t p);
        return int'(p.n_in) + int'(p.m_reg);
    endfunction

endpackage

// File: rtl/pm_stage_delay.sv
module pm_stage_delay #(
    parameter int W = 8,
    parameter int N = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ce,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    if (N == 0) begin : g_pass
        assign q = d;
    end else begin : g_regs
        logic [W-1:0] sr [N];
        always_ff @(posedge clk) begin
            if (ce) begin
                if (rst) begin
                    for (int j = 0; j < N; j++) sr[j] <= '0;
                end else begin
                    sr[0] <= d;
                    for (int j = 1; j < N; j++) sr[j] <= sr[j-1];
                end
            end
        end
        assign q = sr[N-1];
    end
endmodule

// File: rtl/pm_preadd_mult.sv
module pm_preadd_mult #(
    parameter int PRE_W = 24,
    parameter int MUL_W = 18,
    localparam int PROD_W = PRE_W + 1 + MUL_W
) (
    input  logic [PRE_W-1:0]         add_a,
    input  logic [PRE_W-1:0]         add_b,
    input  logic [MUL_W-1:0]         mul_m,
    output logic signed [PROD_W-1:0] prod
);
    // One bit of growth keeps the pre-adder sum exact.
    logic signed [PRE_W:0] sum_s;

    assign sum_s = $signed({add_a[PRE_W-1], add_a}) + $signed({add_b[PRE_W-1], add_b});
    assign prod  = sum_s * $signed(mul_m);
endmodule

// File: rtl/pm_accum.sv
module pm_accum #(
    parameter int PROD_W  = 43,
    parameter int ACC_W   = 48,
    parameter bit OUT_REG = 1'b1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     ce,
    input  logic signed [PROD_W-1:0] prod,
    input  logic                     ld,
    input  logic                     cin,
    input  logic [ACC_W-1:0]         ld_val,
    output logic [ACC_W-1:0]         acc_q,
    output logic [ACC_W-1:0]         result
);
    logic [ACC_W-1:0] prod_ext;
    logic [ACC_W-1:0] base;
    logic [ACC_W-1:0] acc_d;

    always_comb begin
        prod_ext = ACC_W'(prod);
        base     = ld ? ld_val : acc_q;
        acc_d    = base + prod_ext + ACC_W'(cin);
    end

    always_ff @(posedge clk) begin
        if (ce) acc_q <= rst ? '0 : acc_d;
    end

    if (OUT_REG) begin : g_out_reg
        assign result = acc_q;
    end else begin : g_out_comb
        assign result = acc_d;
    end
endmodule

// File: rtl/preadd_macc.sv
module preadd_macc
    import preadd_macc_pkg::*;
#(
    parameter int PRE_W       = 24,
    parameter int MUL_W       = 18,
    parameter int ACC_W       = 48,
    parameter int LATENCY     = 3,
    parameter bit LAT2_OUTREG = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ce,
    input  logic [PRE_W-1:0] pre_a,
    input  logic [PRE_W-1:0] pre_b,
    input  logic [MUL_W-1:0] mul_op,
    input  logic             carry_in,
    input  logic             load,
    input  logic [ACC_W-1:0] load_val,
    output logic [ACC_W-1:0] result
);
    localparam stage_plan_t PLAN   = plan_for(LATENCY, LAT2_OUTREG);
    localparam int          N_IN   = int'(PLAN.n_in);
    localparam int          N_MUL  = int'(PLAN.m_reg);
    localparam int          N_CTL  = ctl_depth(PLAN);
    localparam int          PROD_W = PRE_W + 1 + MUL_W;

    typedef struct packed {
        logic [PRE_W-1:0] a;
        logic [PRE_W-1:0] b;
        logic [MUL_W-1:0] m;
    } opnd_t;

    typedef struct packed {
        logic             ld;
        logic             cin;
        logic [ACC_W-1:0] val;
    } ctl_t;

    localparam int OPND_W = $bits(opnd_t);
    localparam int CTL_W  = $bits(ctl_t);

    opnd_t             opnd_in, opnd_q;
    ctl_t              ctl_in, ctl_q;
    logic [PROD_W-1:0] prod_c, prod_q;
    logic [ACC_W-1:0]  acc_q;

    assign opnd_in = '{a: pre_a, b: pre_b, m: mul_op};
    assign ctl_in  = '{ld: load, cin: carry_in, val: load_val};

    pm_stage_delay #(.W(OPND_W), .N(N_IN)) u_in_pipe (
        .clk(clk), .rst(rst), .ce(ce), .d(opnd_in), .q(opnd_q)
    );

    pm_stage_delay #(.W(CTL_W), .N(N_CTL)) u_ctl_pipe (
        .clk(clk), .rst(rst), .ce(ce), .d(ctl_in), .q(ctl_q)
    );

    pm_preadd_mult #(.PRE_W(PRE_W), .MUL_W(MUL_W)) u_mult (
        .add_a(opnd_q.a), .add_b(opnd_q.b), .mul_m(opnd_q.m), .prod(prod_c)
    );

    pm_stage_delay #(.W(PROD_W), .N(N_MUL)) u_mul_pipe (
        .clk(clk), .rst(rst), .ce(ce), .d(prod_c), .q(prod_q)
    );

    pm_accum #(.PROD_W(PROD_W), .ACC_W(ACC_W), .OUT_REG(PLAN.p_reg)) u_acc (
        .clk(clk), .rst(rst), .ce(ce),
        .prod(prod_q), .ld(ctl_q.ld), .cin(ctl_q.cin), .ld_val(ctl_q.val),
        .acc_q(acc_q), .result(result)
    );
endmodule

// File: rtl/preadd_macc_chk.sv
module preadd_macc_chk
    import preadd_macc_pkg::*;
#(
    parameter int PRE_W       = 24,
    parameter int MUL_W       = 18,
    parameter int ACC_W       = 48,
    parameter int LATENCY     = 3,
    parameter bit LAT2_OUTREG = 1'b1
) (
    input logic             clk,
    input logic             rst,
    input logic             ce,
    input logic [PRE_W-1:0] pre_a,
    input logic [PRE_W-1:0] pre_b,
    input logic [MUL_W-1:0] mul_op,
    input logic             carry_in,
    input logic             load,
    input logic [ACC_W-1:0] load_val,
    input logic [ACC_W-1:0] acc_q,
    input logic [ACC_W-1:0] result
);
    localparam stage_plan_t PLAN = plan_for(LATENCY, LAT2_OUTREG);
    localparam int          D    = ctl_depth(PLAN);

    typedef struct packed {
        logic             ld;
        logic             cin;
        logic             zp;
        logic [ACC_W-1:0] val;
    } tap_t;

    logic [PRE_W:0] psum;
    tap_t           now_s, tail;

    assign psum  = {pre_a[PRE_W-1], pre_a} + {pre_b[PRE_W-1], pre_b};
    assign now_s = '{ld: load, cin: carry_in,
                     zp: (psum == '0) || (mul_op == '0), val: load_val};

    // Port-side view of the controls, aligned to the accumulator edge.
    if (D == 0) begin : g_tap_now
        assign tail = now_s;
    end else begin : g_tap_dly
        tap_t dq [D];
        always_ff @(posedge clk) begin
            if (ce) begin
                if (rst) begin
                    for (int j = 0; j < D; j++) dq[j] <= '{ld: 1'b0, cin: 1'b0, zp: 1'b1, val: '0};
                end else begin
                    dq[0] <= now_s;
                    for (int j = 1; j < D; j++) dq[j] <= dq[j-1];
                end
            end
        end
        assign tail = dq[D-1];
    end

    // R3
    load_seed_chk: assert property (@(posedge clk) disable iff (rst)
        (ce && tail.ld && tail.zp) |=> (acc_q == $past(tail.val + ACC_W'(tail.cin))));

    // R2
    accum_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (ce && !tail.ld && tail.zp && !tail.cin) |=> $stable(acc_q));

    // R8
    ce_hold_acc_chk: assert property (@(posedge clk) disable iff (rst)
        !ce |=> $stable(acc_q));

    if (LATENCY >= 1) begin : g_reg_out
        // R8
        ce_hold_out_chk: assert property (@(posedge clk) disable iff (rst)
            !ce |=> $stable(result));

        // R9
        reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
            $past(rst && ce) |-> (result == '0));
    end
endmodule

bind preadd_macc preadd_macc_chk #(
    .PRE_W(PRE_W), .MUL_W(MUL_W), .ACC_W(ACC_W),
    .LATENCY(LATENCY), .LAT2_OUTREG(LAT2_OUTREG)
) u_chk (
    .clk(clk), .rst(rst), .ce(ce),
    .pre_a(pre_a), .pre_b(pre_b), .mul_op(mul_op),
    .carry_in(carry_in), .load(load), .load_val(load_val),
    .acc_q(acc_q), .result(result)
);

// File: tb/preadd_macc_tb.sv
module preadd_macc_tb;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               ce  = 1'b1;
    logic signed [23:0] pa  = '0;
    logic signed [23:0] pb  = '0;
    logic signed [17:0] mm  = '0;
    logic               cin = 1'b0;
    logic               ld  = 1'b0;
    logic [47:0]        ldv = '0;
    logic [47:0]        r1, r3, r4;

    int nchk  = 0;
    int nfail = 0;
    int k     = 0;
    bit done  = 1'b0;
    logic [47:0] model = '0;
    logic [47:0] hist [1024];

    always #10ns clk = ~clk;

    preadd_macc #(.LATENCY(1)) u_dut_l1 (
        .clk(clk), .rst(rst), .ce(ce), .pre_a(pa), .pre_b(pb), .mul_op(mm),
        .carry_in(cin), .load(ld), .load_val(ldv), .result(r1)
    );
    preadd_macc u_dut (
        .clk(clk), .rst(rst), .ce(ce), .pre_a(pa), .pre_b(pb), .mul_op(mm),
        .carry_in(cin), .load(ld), .load_val(ldv), .result(r3)
    );
    preadd_macc #(.LATENCY(4)) u_dut_l4 (
        .clk(clk), .rst(rst), .ce(ce), .pre_a(pa), .pre_b(pb), .mul_op(mm),
        .carry_in(cin), .load(ld), .load_val(ldv), .result(r4)
    );

    function automatic logic [47:0] contrib(input logic signed [23:0] a, input logic signed [23:0] b,
                                            input logic signed [17:0] m);
        longint s;
        longint p;
        s = longint'(a) + longint'(b);
        p = s * longint'(m);
        return p[47:0];
    endfunction

    task automatic check(input string tag, input int lat, input logic [47:0] got);
        logic [47:0] expv;
        expv = (k >= lat) ? hist[k-lat] : 48'd0;
        nchk++;
        if (got !== expv) begin
            nfail++;
            $display("FAIL %s latency=%0d got=%h expected=%h", tag, lat, got, expv);
        end
    endtask

    // One clock: drive at the falling edge, model the rising edge, compare at the next falling edge.
    task automatic tick(input string tag, input logic signed [23:0] a, input logic signed [23:0] b,
                        input logic signed [17:0] m, input logic c, input logic l,
                        input logic [47:0] lv, input logic e, input logic r);
        pa = a; pb = b; mm = m; cin = c; ld = l; ldv = lv; ce = e; rst = r;
        @(posedge clk);
        if (e) begin
            if (r) begin
                k = 0;
                model = '0;
            end else begin
                model = (l ? lv : model) + contrib(a, b, m) + {47'd0, c};
                hist[k] = model;
                k++;
            end
        end
        @(negedge clk);
        check(tag, 1, r1);
        check(tag, 3, r3);
        check(tag, 4, r4);
    endtask

    task automatic flush(input string tag, input int n);
        for (int i = 0; i < n; i++) tick(tag, 0, 0, 0, 0, 0, 48'd0, 1, 0);
    endtask

    task automatic do_reset();
        tick("R9", 0, 0, 0, 0, 0, 48'd0, 1, 1);
    endtask

    task automatic t_reset();
        do_reset();
        do_reset();
        tick("R9", 5, 6, 7, 1, 0, 48'd0, 1, 0);
        tick("R9", -9, 2, 3, 0, 0, 48'd0, 1, 0);
        tick("R9", 11, 0, 4, 0, 0, 48'd0, 1, 0);
        // Reset mid-stream with a load pending: everything must clear.
        tick("R9", 40, 1, 9, 1, 1, 48'h1234, 1, 1);
        flush("R9", 4);
    endtask

    task automatic t_accum();
        do_reset();
        tick("R2", 3, 4, 5, 0, 0, 48'd0, 1, 0);
        tick("R2", -2, 1, 7, 0, 0, 48'd0, 1, 0);
        tick("R2", 100, -50, -3, 0, 0, 48'd0, 1, 0);
        tick("R2", -1000, -24, 250, 0, 0, 48'd0, 1, 0);
        flush("R6/R7", 5);
    endtask

    task automatic t_impulse();
        do_reset();
        tick("R6", 1, 0, 1, 0, 0, 48'd0, 1, 0);
        flush("R6/R7", 5);
    endtask

    task automatic t_growth();
        do_reset();
        tick("R1", 24'sh7FFFFF, 24'sh7FFFFF, -2, 0, 0, 48'd0, 1, 0);
        tick("R1", 24'sh800000, 24'sh800000, 3, 0, 0, 48'd0, 1, 0);
        tick("R1", 24'sh7FFFFF, 24'sh7FFFFF, 18'sh1FFFF, 0, 0, 48'd0, 1, 0);
        tick("R1", 24'sh800000, 24'sh800000, 18'sh20000, 0, 0, 48'd0, 1, 0);
        flush("R1", 5);
    endtask

    task automatic t_carry();
        do_reset();
        tick("R4", 0, 0, 0, 1, 0, 48'd0, 1, 0);
        tick("R4", 0, 0, 0, 1, 0, 48'd0, 1, 0);
        tick("R4", 6, 0, 6, 1, 0, 48'd0, 1, 0);
        tick("R4", 0, 0, 0, 0, 0, 48'd0, 1, 0);
        tick("R4", 0, 0, 0, 1, 0, 48'd0, 1, 0);
        flush("R4", 5);
    endtask

    task automatic t_load();
        do_reset();
        tick("R2", 50, 50, 50, 0, 0, 48'd0, 1, 0);
        tick("R2", 50, 50, 50, 0, 0, 48'd0, 1, 0);
        tick("R3/R10", 2, 3, 4, 0, 1, 48'd1000, 1, 0);
        tick("R2", 1, 1, 1, 0, 0, 48'd0, 1, 0);
        tick("R3/R10", -5, 1, 10, 1, 1, 48'hFFFF_0000_0000, 1, 0);
        tick("R3/R10", 0, 0, 0, 0, 1, 48'd77, 1, 0);
        tick("R3/R10", 9, 9, -9, 1, 1, 48'd5, 1, 0);
        tick("R2", 3, 0, 3, 0, 0, 48'hAAAA_AAAA_AAAA, 1, 0);
        flush("R3/R10", 5);
    endtask

    task automatic t_ce();
        do_reset();
        tick("R8", 7, 8, 9, 0, 0, 48'd0, 1, 0);
        tick("R8", 1, 2, 3, 1, 0, 48'd0, 1, 0);
        tick("R8", 24'sh7FFFFF, -3, 18'sh1FFFF, 1, 1, 48'hDEAD_BEEF_0001, 0, 0);
        tick("R8", -100, 99, 55, 1, 0, 48'd0, 0, 0);
        tick("R8", 12, 12, 12, 1, 1, 48'h1, 0, 1);
        tick("R8", 0, 0, 0, 0, 0, 48'd0, 0, 1);
        tick("R8", 4, 4, 4, 0, 0, 48'd0, 1, 0);
        flush("R8", 5);
    endtask

    task automatic t_wrap();
        do_reset();
        tick("R5", -1, 0, 1, 0, 0, 48'd0, 1, 0);
        tick("R5", 0, 0, 0, 0, 1, 48'h7FFF_FFFF_FFFF, 1, 0);
        tick("R5", 0, 0, 0, 1, 0, 48'd0, 1, 0);
        tick("R5", 1000, 0, 1000, 0, 0, 48'd0, 1, 0);
        tick("R5", 0, 0, 0, 1, 1, 48'hFFFF_FFFF_FFFF, 1, 0);
        tick("R5", 24'sh7FFFFF, 24'sh7FFFFF, 18'sh1FFFF, 0, 0, 48'd0, 1, 0);
        flush("R5", 5);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_accum();
        t_impulse();
        t_growth();
        t_carry();
        t_load();
        t_ce();
        t_wrap();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        #4ms;
        if (!done) begin
            done = 1'b1;
            nfail++;
            $display("FAIL watchdog: run did not finish, got=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

endmodule